// File: doc/BRIEF.md
# USART Register and Flag Layer

This block is the software-visible face of a serial port. A simple memory-mapped bus (address, write strobe, write data, read strobe, read data) reaches a status word, a data word, a baud word, three control words and a guard/prescale word. Received characters arrive one byte at a time on a stream input with a ready handshake. Characters written by software leave on a stream output as a one-cycle valid strobe. A single level interrupt line reports a waiting received character.

Line timing, oversampling, parity and framing belong to a separate serializer. The baud and guard words are stored and read back, and have no other effect. The flags do have side effects. A status read clears the "transmit done" flag. A data read clears "receive full", sets "transmit empty" and drops the interrupt. A status write can only clear bits, because the written value is ANDed into the register. The interrupt is re-evaluated when status or control word 1 is written.

Top module: `usart_regfile`

## Requirements
- R1: `rx_ready` is high exactly while the receive-full flag (status bit 5) is clear. While a character is held, no other character is taken and the held data word does not change.
- R2: An offered character is consumed and thrown away unless control word 1 has both the port-enable bit (bit 13) and the receive-enable bit (bit 2) set. A discarded character leaves status bit 5 clear.
- R3: An accepted character is stored in the data word, and status bit 5 is set on the next clock edge. If the receive-interrupt enable bit of control word 1 (bit 5) is set, `irq` rises on that same edge.
- R4: A status read (offset 0x00) returns the value the register holds before the read. Transmit-done (status bit 6) is clear after the read.
- R5: A data read (offset 0x04) returns the low 10 bits of the data word, zero-extended. Afterwards transmit-empty (status bit 7) is set, status bit 5 is clear and `irq` is low.
- R6: A status write stores the old status ANDed with the written value. If status bit 5 is then clear, `irq` goes low. `irq` is never high while status bit 5 is clear.
- R7: A data write produces one cycle of `tx_valid`, in the cycle after the write, with `tx_data` equal to write-data bits 7:0. The write stores write-data bits 9:0 in the data word, sets status bit 6 and clears status bit 7.
- R8: A control-word-1 write (offset 0x0C) that has bit 5 set while status bit 5 is set raises `irq` on the next edge.
- R9: After reset, status reads 0x000000C0, every other word reads zero, `irq` is low and `rx_ready` is high.
- R10: The word offsets are status 0x00, data 0x04, baud 0x08, control1 0x0C, control2 0x10, control3 0x14 and guard 0x18, inside a 13-bit (0x2000-byte) window. Any other address reads zero, and writes to it change no register.
- R11: The baud, control2, control3 and guard words store all 32 written bits and read them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is active |
| rx_valid | input | 1 | A received character is offered |
| rx_data | input | 8 | Offered character |
| rx_ready | output | 1 | Character can be taken |
| tx_valid | output | 1 | One-cycle strobe for an outgoing character |
| tx_data | output | 8 | Outgoing character |
| irq | output | 1 | Receive interrupt level |

## Verification
The bound checker evaluates the flag rules on every cycle. It covers the invariant that the interrupt implies receive-full, the flag effects of status and data reads, the transmit strobe following a data write, interrupt raising on a control write, discarding while disabled, and the held data word staying stable while full. Some behaviour only the directed scenarios can show: the exact read values and reset contents, the readback of the stored-only words, decoding of unmapped and misaligned addresses, and the order of events when a second character is offered while one is held.

// File: rtl/usart_regs_pkg.sv
package usart_regs_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 10;
    localparam int CHAR_W = 8;

    // status flag positions
    localparam int ST_RXFULL  = 5;
    localparam int ST_TXDONE  = 6;
    localparam int ST_TXEMPTY = 7;
    // control word 1 bit positions
    localparam int C1_RXIE  = 5;
    localparam int C1_RXEN  = 2;
    localparam int C1_PORTEN = 13;

    localparam logic [REG_W-1:0] STAT_RESET = 32'h0000_00C0;

    localparam logic [ADDR_W-1:0] OFF_STAT  = 13'h00;
    localparam logic [ADDR_W-1:0] OFF_DATA  = 13'h04;
    localparam logic [ADDR_W-1:0] OFF_BAUD  = 13'h08;
    localparam logic [ADDR_W-1:0] OFF_CTL1  = 13'h0C;
    localparam logic [ADDR_W-1:0] OFF_CTL2  = 13'h10;
    localparam logic [ADDR_W-1:0] OFF_CTL3  = 13'h14;
    localparam logic [ADDR_W-1:0] OFF_GUARD = 13'h18;

    typedef enum logic [2:0] {
        SEL_STAT, SEL_DATA, SEL_BAUD, SEL_CTL1,
        SEL_CTL2, SEL_CTL3, SEL_GUARD, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0]  stat;
        logic [DATA_W-1:0] dat;
        logic [REG_W-1:0]  baud;
        logic [REG_W-1:0]  ctl1;
        logic [REG_W-1:0]  ctl2;
        logic [REG_W-1:0]  ctl3;
        logic [REG_W-1:0]  guard;
        logic              irq;
        logic              tx_valid;
        logic [CHAR_W-1:0] tx_char;
    } regs_t;
endpackage

// File: rtl/usart_addr_decode.sv
module usart_addr_decode
    import usart_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        unique case (addr)
            OFF_STAT:  sel = SEL_STAT;
            OFF_DATA:  sel = SEL_DATA;
            OFF_BAUD:  sel = SEL_BAUD;
            OFF_CTL1:  sel = SEL_CTL1;
            OFF_CTL2:  sel = SEL_CTL2;
            OFF_CTL3:  sel = SEL_CTL3;
            OFF_GUARD: sel = SEL_GUARD;
            default:   sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/usart_rx_gate.sv
module usart_rx_gate (
    input  logic rx_valid,
    input  logic rx_full,
    input  logic port_en,
    input  logic rx_en,
    output logic rx_ready,
    output logic take,
    output logic drop
);
    logic offered;
    always_comb begin
        rx_ready = ~rx_full;
        offered  = rx_valid & ~rx_full;
        take     = offered & port_en & rx_en;
        drop     = offered & ~(port_en & rx_en);
    end
endmodule

// File: rtl/usart_regfile.sv
module usart_regfile
    import usart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    output logic              irq
);
    localparam int DPAD = DATA_W - CHAR_W;

    regs_t    s_d, s_q;
    reg_sel_e sel;
    logic     take, drop;

    // observation points for the bound checker
    logic [REG_W-1:0]  stat_w;
    logic [REG_W-1:0]  ctl1_w;
    logic [DATA_W-1:0] dat_w;

    usart_addr_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    usart_rx_gate u_rx (
        .rx_valid (rx_valid),
        .rx_full  (s_q.stat[ST_RXFULL]),
        .port_en  (s_q.ctl1[C1_PORTEN]),
        .rx_en    (s_q.ctl1[C1_RXEN]),
        .rx_ready (rx_ready),
        .take     (take),
        .drop     (drop)
    );

    always_comb begin
        s_d = s_q;
        s_d.tx_valid = 1'b0;

        // read side effects
        if (bus_rd) begin
            if (sel == SEL_STAT) begin
                s_d.stat[ST_TXDONE] = 1'b0;
            end else if (sel == SEL_DATA) begin
                s_d.stat[ST_TXEMPTY] = 1'b1;
                s_d.stat[ST_RXFULL]  = 1'b0;
                s_d.irq              = 1'b0;
            end
        end

        // write effects
        if (bus_wr) begin
            unique case (sel)
                SEL_STAT: begin
                    s_d.stat = s_d.stat & bus_wdata;
                    if (!s_d.stat[ST_RXFULL]) s_d.irq = 1'b0;
                end
                SEL_DATA: begin
                    s_d.dat                = bus_wdata[DATA_W-1:0];
                    s_d.tx_valid           = 1'b1;
                    s_d.tx_char            = bus_wdata[CHAR_W-1:0];
                    s_d.stat[ST_TXDONE]    = 1'b1;
                    s_d.stat[ST_TXEMPTY]   = 1'b0;
                end
                SEL_BAUD:  s_d.baud  = bus_wdata;
                SEL_CTL1: begin
                    s_d.ctl1 = bus_wdata;
                    if (bus_wdata[C1_RXIE] && s_d.stat[ST_RXFULL]) s_d.irq = 1'b1;
                end
                SEL_CTL2:  s_d.ctl2  = bus_wdata;
                SEL_CTL3:  s_d.ctl3  = bus_wdata;
                SEL_GUARD: s_d.guard = bus_wdata;
                default: ;
            endcase
        end

        // receive path; a dropped character needs no state change
        if (take) begin
            s_d.dat              = {{DPAD{1'b0}}, rx_data};
            s_d.stat[ST_RXFULL]  = 1'b1;
            if (s_d.ctl1[C1_RXIE]) s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.stat  <= STAT_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_STAT:  bus_rdata = s_q.stat;
                SEL_DATA:  bus_rdata = {{(REG_W-DATA_W){1'b0}}, s_q.dat};
                SEL_BAUD:  bus_rdata = s_q.baud;
                SEL_CTL1:  bus_rdata = s_q.ctl1;
                SEL_CTL2:  bus_rdata = s_q.ctl2;
                SEL_CTL3:  bus_rdata = s_q.ctl3;
                SEL_GUARD: bus_rdata = s_q.guard;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign tx_valid = s_q.tx_valid;
    assign tx_data  = s_q.tx_char;
    assign irq      = s_q.irq;
    assign stat_w   = s_q.stat;
    assign ctl1_w   = s_q.ctl1;
    assign dat_w    = s_q.dat;

    logic unused_drop;
    assign unused_drop = drop;
endmodule

// File: rtl/usart_regfile_chk.sv
module usart_regfile_chk
    import usart_regs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              bus_rd,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [CHAR_W-1:0] tx_data,
    input logic              irq,
    input logic [REG_W-1:0]  stat,
    input logic [REG_W-1:0]  ctl1,
    input logic [DATA_W-1:0] dat
);
    // R1: a held character stays put while the bus is idle
    p_single_char_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat[ST_RXFULL] && !bus_wr && !bus_rd |=> stat[ST_RXFULL] && $stable(dat));

    // R2: a character offered while disabled is not kept
    p_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && !(ctl1[C1_PORTEN] && ctl1[C1_RXEN]) && !bus_wr && !bus_rd
        |=> !stat[ST_RXFULL]);

    // R4: status read clears transmit-done
    p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == OFF_STAT && !bus_wr |=> !stat[ST_TXDONE]);

    // R5: data read flag effects
    p_data_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == OFF_DATA && !bus_wr && !(rx_valid && rx_ready)
        |=> !irq && !stat[ST_RXFULL] && stat[ST_TXEMPTY]);

    // R6: the interrupt never outlives receive-full
    p_irq_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat[ST_RXFULL]);

    // R7: data write gives one transmit strobe with the low byte
    p_tx_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == OFF_DATA
        |=> tx_valid && tx_data == $past(bus_wdata[CHAR_W-1:0])
            && stat[ST_TXDONE] && !stat[ST_TXEMPTY]);

    p_tx_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFF_DATA) |=> !tx_valid);

    // R8: enabling the interrupt with a pending character raises it
    p_ctl_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !bus_rd && bus_addr == OFF_CTL1 && bus_wdata[C1_RXIE] && stat[ST_RXFULL]
        |=> irq);
endmodule

bind usart_regfile usart_regfile_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .irq       (irq),
    .stat      (stat_w),
    .ctl1      (ctl1_w),
    .dat       (dat_w)
);

// File: tb/usart_regfile_tb.sv
module usart_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    usart_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] c, output logic rdy);
        @(negedge clk);
        rx_data = c; rx_valid = 1'b1;
        #1 rdy = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R9 irq", {31'b0, irq}, 0);
        check("R9 rx_ready", {31'b0, rx_ready}, 1);
        check("R9 tx_valid", {31'b0, tx_valid}, 0);
        rd(13'h00, v); check("R9 status", v, 32'hC0);
        rd(13'h00, v); check("R4 tc cleared", v, 32'h80);
        rd(13'h0C, v); check("R9 ctl1", v, 0);
        rd(13'h08, v); check("R9 baud", v, 0);
        rd(13'h18, v); check("R9 guard", v, 0);
    endtask

    task automatic t_storage;
        logic [31:0] v;
        wr(13'h08, 32'hDEADBEEF);
        wr(13'h10, 32'h1234ABCD);
        wr(13'h14, 32'hFFFF0001);
        wr(13'h18, 32'h8000FFFE);
        rd(13'h08, v); check("R11 baud", v, 32'hDEADBEEF);
        rd(13'h10, v); check("R11 ctl2", v, 32'h1234ABCD);
        rd(13'h14, v); check("R11 ctl3", v, 32'hFFFF0001);
        rd(13'h18, v); check("R11 guard", v, 32'h8000FFFE);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(13'h1C, 32'h5555AAAA);
        wr(13'h09, 32'h0);
        rd(13'h1C, v); check("R10 unmapped read", v, 0);
        rd(13'h0E, v); check("R10 misaligned read", v, 0);
        rd(13'h1FFC, v); check("R10 top of window", v, 0);
        rd(13'h08, v); check("R10 baud untouched", v, 32'hDEADBEEF);
        rd(13'h00, v); check("R10 status untouched", v, 32'h80);
        check("R10 no tx", {31'b0, tx_valid}, 0);
    endtask

    task automatic t_receive;
        logic [31:0] v;
        logic r;
        wr(13'h0C, 32'h0000_0004);
        push(8'h41, r);
        rd(13'h00, v); check("R2 drop rx-only", v, 32'h80);
        wr(13'h0C, 32'h0000_2000);
        push(8'h42, r);
        rd(13'h00, v); check("R2 drop port-only", v, 32'h80);
        wr(13'h0C, 32'h0000_2004);
        push(8'h5A, r);
        check("R1 ready before", {31'b0, r}, 1);
        check("R1 ready low when full", {31'b0, rx_ready}, 0);
        check("R3 no irq without enable", {31'b0, irq}, 0);
        push(8'h33, r);
        check("R1 second offer refused", {31'b0, r}, 0);
        rd(13'h00, v); check("R3 full flag", v, 32'hA0);
        rd(13'h04, v); check("R1 first char kept", v, 32'h05A);
        rd(13'h00, v); check("R5 flags after data read", v, 32'h80);
        check("R1 ready again", {31'b0, rx_ready}, 1);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        logic r;
        wr(13'h0C, 32'h0000_2024);
        push(8'h7E, r);
        check("R3 irq raised", {31'b0, irq}, 1);
        rd(13'h04, v); check("R5 data value", v, 32'h07E);
        check("R5 irq dropped", {31'b0, irq}, 0);
        wr(13'h0C, 32'h0000_2004);
        push(8'h11, r);
        check("R3 irq stays low", {31'b0, irq}, 0);
        wr(13'h0C, 32'h0000_2024);
        check("R8 irq on ctl write", {31'b0, irq}, 1);
        wr(13'h00, 32'hFFFF_FFDF);
        check("R6 irq cleared by status write", {31'b0, irq}, 0);
        check("R6 ready after clear", {31'b0, rx_ready}, 1);
        rd(13'h00, v); check("R6 status after and", v, 32'h80);
        wr(13'h00, 32'hFFFF_FF7F);
        rd(13'h00, v); check("R6 empty flag cleared", v, 32'h00);
        wr(13'h00, 32'hFFFF_FFFF);
        rd(13'h00, v); check("R6 write cannot set", v, 32'h00);
        rd(13'h04, v);
        rd(13'h00, v); check("R5 data read sets empty", v, 32'h80);
    endtask

    task automatic t_transmit;
        logic [31:0] v;
        wr(13'h04, 32'h0000_01A5);
        check("R7 tx_valid", {31'b0, tx_valid}, 1);
        check("R7 tx_data", {24'b0, tx_data}, 32'hA5);
        @(negedge clk);
        check("R7 single strobe", {31'b0, tx_valid}, 0);
        rd(13'h00, v); check("R7 done set empty clear", v, 32'h40);
        rd(13'h00, v); check("R4 done cleared", v, 32'h00);
        rd(13'h04, v); check("R5 stored word", v, 32'h1A5);
        wr(13'h04, 32'h0000_FFFF);
        check("R7 tx_data low byte", {24'b0, tx_data}, 32'hFF);
        rd(13'h04, v); check("R5 ten bits", v, 32'h3FF);
        rd(13'h00, v); check("R7 status after read", v, 32'hC0);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_storage();
        t_unmapped();
        t_receive();
        t_irq();
        t_transmit();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule